// File: doc/BRIEF.md
# Serial configuration port controller

This block is a slave serial port that lets an external host read and write a small bank of configuration registers. The host opens each transaction with an instruction byte. That byte holds a direction flag and a 5-bit register address. A data phase follows, and its length in bytes is the width of the addressed register. Every register drives a parallel output that the surrounding logic can use. Register 2 is also split into a 2-bit ramp-rate field and a 14-bit amplitude scale value.

The serial lines are asynchronous to the system clock. A two-or-more-stage synchronizer brings them into the system clock domain, and edges of the serial clock are detected there. The host samples input data on the rising edge of the serial clock. Read data changes after the falling edge.

Two bits of register 0 set how the port behaves. One bit sets the bit and byte order. The other bit sets whether read data leaves on the shared data line (3-wire) or on a separate output line (4-wire). Chip select pauses a transaction and does not end it. A separate abort input ends the transaction at once. Each output line is driven through a data/enable pair, so the pad ring can build the tri-state buffers.

Top module: `cfg_serial_port`

## Requirements
- R1: Instruction byte: bit 7 set means read and clear means write. Bits 6 and 5 have no effect. Bits 4..0 give the register address.
- R2: Data phase length: register 1 is 3 bytes, register 2 is 2 bytes, and all other addresses (0, 3, 4, 5 and every unmapped address 6..31) are 4 bytes. An unmapped address reads as zero, and a write to it changes no register.
- R3: With register 0 bit 8 clear (reset), the instruction byte is shifted in MSB first. Data moves from the most significant byte down, and each byte is MSB first. The host samples bits on the rising edge of the serial clock.
- R4: With register 0 bit 8 set, the instruction byte is shifted in LSB first. Data moves from the least significant byte up, and each byte is LSB first. A change to the order takes effect from the next transaction.
- R5: With register 0 bit 7 clear, read data is driven on `sdio_o` with `sdio_oe_o` high, and `sdo_oe_o` stays low. With bit 7 set, read data goes on `sdo_o` with `sdo_oe_o` high, and `sdio_oe_o` stays low. The two enables are never high together.
- R6: While `csn_i` is high, both output enables are low and serial clock edges are ignored. The transaction resumes from the same bit when `csn_i` returns low.
- R7: A high level on `sync_i` aborts the transaction without touching any register. The next bits are taken as a new instruction byte.
- R8: A write is copied into its register in one step, after the last data bit. An aborted or incomplete write leaves the register unchanged.
- R9: `ramp_o` is bits 15..14 of register 2, and `scale_o` is bits 13..0 of register 2.
- R10: After reset, every register is zero and both output enables are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, faster than the serial clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sclk_i | input | 1 | Serial clock from the host |
| csn_i | input | 1 | Active-low chip select; high pauses the transaction |
| sdio_i | input | 1 | Serial data into the port |
| sync_i | input | 1 | Active-high transaction abort |
| sdio_o | output | 1 | Read data on the shared line (3-wire) |
| sdio_oe_o | output | 1 | Drive enable for the shared line |
| sdo_o | output | 1 | Read data on the separate line (4-wire) |
| sdo_oe_o | output | 1 | Drive enable for the separate line |
| cfg_o | output | NUM_REGS*32 | Register contents, 32 bits per register, zero-extended |
| ramp_o | output | 2 | Ramp-rate field of register 2 |
| scale_o | output | 14 | Amplitude scale field of register 2 |

## Verification
The bench builds the block with its default values, `NUM_REGS = 6` and `SYNC_STAGES = 2`. With six mapped registers, addresses 6 to 31 fall in the unmapped range, so the zero readback and the ignored write can be reached at address 0x10. The serial clock runs at one twentieth of the system clock. That gives the two-stage synchronizer room to settle before each sampled edge. Each width (2, 3 and 4 bytes) is run in both bit orders and both line modes, including transactions that are paused and aborted mid-stream.

// File: rtl/cfgsp_pkg.sv
package cfgsp_pkg;

   localparam int unsigned ADDR_W    = 5;
   localparam int unsigned MAX_BYTES = 4;
   localparam int unsigned DATA_W    = 8 * MAX_BYTES;
   localparam int unsigned ORDER_BIT = 8;   // register 0: 1 = LSB first
   localparam int unsigned LINE_BIT  = 7;   // register 0: 1 = separate output line

   typedef enum logic {
      PH_INSTR = 1'b0,
      PH_DATA  = 1'b1
   } phase_t;

   // Width in bytes of the register at a given address.
   function automatic int unsigned reg_bytes(input logic [ADDR_W-1:0] a);
      case (a)
         5'd1:    return 3;
         5'd2:    return 2;
         default: return MAX_BYTES;
      endcase
   endfunction

endpackage

// File: rtl/cfgsp_sync.sv
module cfgsp_sync #(
   parameter int unsigned       WIDTH   = 4,
   parameter int unsigned       STAGES  = 2,
   parameter logic [WIDTH-1:0]  RST_VAL = '0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] d,
   output logic [WIDTH-1:0] q
);

   if (STAGES < 2) begin : g_bad_stages
      $error("cfgsp_sync: STAGES must be at least 2");
   end
   if (WIDTH < 1) begin : g_bad_width
      $error("cfgsp_sync: WIDTH must be at least 1");
   end

   logic [WIDTH-1:0] st [STAGES];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < int'(STAGES); i++) st[i] <= RST_VAL;
      end else begin
         st[0] <= d;
         for (int i = 1; i < int'(STAGES); i++) st[i] <= st[i-1];
      end
   end

   assign q = st[STAGES-1];

endmodule

// File: rtl/cfgsp_engine.sv
module cfgsp_engine
   import cfgsp_pkg::*;
(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              sclk_s,
   input  logic              csn_s,
   input  logic              sdi_s,
   input  logic              sync_s,
   input  logic              lsb_first,
   input  logic [DATA_W-1:0] rd_data,
   output logic [ADDR_W-1:0] addr,
   output logic              wr_en,
   output logic [DATA_W-1:0] wr_data,
   output logic              tx_bit,
   output logic              tx_active
);

   localparam int unsigned BCNT_W = $clog2(DATA_W + 1);
   localparam int unsigned IDX_W  = $clog2(DATA_W);

   phase_t             phase_q;
   logic [BCNT_W-1:0]  bit_cnt;
   logic [BCNT_W-1:0]  nbits_q;
   logic [7:0]         instr_q;
   logic [7:0]         instr_nxt;
   logic               rw_q;
   logic               sclk_q;
   logic [DATA_W-1:0]  shadow_q;
   logic [DATA_W-1:0]  shadow_nxt;
   logic [IDX_W-1:0]   idx;
   logic               rise;
   logic               fall;
   logic               last_data;

   assign rise = sclk_s & ~sclk_q & ~csn_s & ~sync_s;
   assign fall = ~sclk_s & sclk_q & ~csn_s & ~sync_s;

   assign instr_nxt = lsb_first ? {sdi_s, instr_q[7:1]} : {instr_q[6:0], sdi_s};

   // Register bit touched by the current data bit.
   assign idx = lsb_first ? IDX_W'(bit_cnt)
                          : IDX_W'(nbits_q - BCNT_W'(1) - bit_cnt);

   assign last_data = (bit_cnt == nbits_q - BCNT_W'(1));

   always_comb begin
      shadow_nxt      = shadow_q;
      shadow_nxt[idx] = sdi_s;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase_q   <= PH_INSTR;
         bit_cnt   <= '0;
         nbits_q   <= BCNT_W'(DATA_W);
         instr_q   <= '0;
         rw_q      <= 1'b0;
         addr      <= '0;
         sclk_q    <= 1'b0;
         shadow_q  <= '0;
         wr_en     <= 1'b0;
         wr_data   <= '0;
         tx_bit    <= 1'b0;
         tx_active <= 1'b0;
      end else begin
         sclk_q    <= sclk_s;
         wr_en     <= 1'b0;
         tx_active <= (phase_q == PH_DATA) && rw_q && !csn_s && !sync_s;
         if (sync_s) begin
            phase_q <= PH_INSTR;
            bit_cnt <= '0;
         end else if (rise) begin
            if (phase_q == PH_INSTR) begin
               instr_q <= instr_nxt;
               if (bit_cnt == BCNT_W'(7)) begin
                  phase_q  <= PH_DATA;
                  bit_cnt  <= '0;
                  rw_q     <= instr_nxt[7];
                  addr     <= instr_nxt[ADDR_W-1:0];
                  nbits_q  <= BCNT_W'(reg_bytes(instr_nxt[ADDR_W-1:0]) * 8);
                  shadow_q <= '0;
               end else begin
                  bit_cnt <= bit_cnt + BCNT_W'(1);
               end
            end else begin
               if (!rw_q) shadow_q <= shadow_nxt;
               if (last_data) begin
                  phase_q <= PH_INSTR;
                  bit_cnt <= '0;
                  if (!rw_q) begin
                     wr_en   <= 1'b1;
                     wr_data <= shadow_nxt;
                  end
               end else begin
                  bit_cnt <= bit_cnt + BCNT_W'(1);
               end
            end
         end else if (fall && phase_q == PH_DATA && rw_q) begin
            tx_bit <= rd_data[idx];
         end
      end
   end

   // R7: an abort returns the engine to the instruction phase and blocks a commit
   p_sync_abort_r7: assert property (@(posedge clk) disable iff (!rst_n)
      sync_s |=> (phase_q == PH_INSTR && bit_cnt == '0 && !wr_en));

   // R6: chip select high silences the read path
   p_csn_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
      csn_s |=> !tx_active);

   // R6: chip select high freezes the position in the transaction
   p_csn_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (csn_s && !sync_s) |=> ($stable(bit_cnt) && $stable(phase_q)));

   // R8: a commit is a single-cycle strobe
   p_commit_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |=> !wr_en);

endmodule

// File: rtl/cfgsp_regbank.sv
module cfgsp_regbank
   import cfgsp_pkg::*;
#(
   parameter int unsigned NUM_REGS = 6
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       wr_en,
   input  logic [ADDR_W-1:0]          addr,
   input  logic [DATA_W-1:0]          wr_data,
   output logic [DATA_W-1:0]          rd_data,
   output logic [NUM_REGS*DATA_W-1:0] bank_o
);

   logic [NUM_REGS*DATA_W-1:0] bank_flat;

   for (genvar g = 0; g < int'(NUM_REGS); g++) begin : g_reg
      localparam int unsigned W = reg_bytes(ADDR_W'(g)) * 8;
      logic [W-1:0] q;

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)                              q <= '0;
         else if (wr_en && addr == ADDR_W'(g))    q <= wr_data[W-1:0];
      end

      if (W == DATA_W) begin : g_full
         assign bank_flat[g*DATA_W +: DATA_W] = q;
      end else begin : g_ext
         assign bank_flat[g*DATA_W +: DATA_W] = {{(DATA_W-W){1'b0}}, q};
      end
   end

   always_comb begin
      rd_data = '0;
      for (int i = 0; i < int'(NUM_REGS); i++) begin
         if (addr == ADDR_W'(i)) rd_data = bank_flat[i*DATA_W +: DATA_W];
      end
   end

   assign bank_o = bank_flat;

   // R2: a write to an unmapped address leaves every register alone
   p_unmapped_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && addr >= ADDR_W'(NUM_REGS)) |=> $stable(bank_o));

   // R8: registers change only on a commit strobe
   p_no_commit_r8: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_en |=> $stable(bank_o));

endmodule

// File: rtl/cfg_serial_port.sv
module cfg_serial_port
   import cfgsp_pkg::*;
#(
   parameter int unsigned NUM_REGS    = 6,
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       sclk_i,
   input  logic                       csn_i,
   input  logic                       sdio_i,
   input  logic                       sync_i,
   output logic                       sdio_o,
   output logic                       sdio_oe_o,
   output logic                       sdo_o,
   output logic                       sdo_oe_o,
   output logic [NUM_REGS*32-1:0]     cfg_o,
   output logic [1:0]                 ramp_o,
   output logic [13:0]                scale_o
);

   if (NUM_REGS < 3 || NUM_REGS > (1 << ADDR_W)) begin : g_bad_regs
      $error("cfg_serial_port: NUM_REGS must lie in 3..32");
   end
   if (DATA_W != 32) begin : g_bad_dw
      $error("cfg_serial_port: port width assumes 32-bit register slots");
   end

   logic [3:0]         raw_in;
   logic [3:0]         syn_in;
   logic               sclk_s, csn_s, sdi_s, sync_s;
   logic [ADDR_W-1:0]  addr;
   logic               wr_en;
   logic [DATA_W-1:0]  wr_data;
   logic [DATA_W-1:0]  rd_data;
   logic               tx_bit;
   logic               tx_active;
   logic               line4;
   logic               lsb_first;

   assign raw_in = {sync_i, sdio_i, csn_i, sclk_i};

   cfgsp_sync #(
      .WIDTH   (4),
      .STAGES  (SYNC_STAGES),
      .RST_VAL (4'b0010)
   ) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d     (raw_in),
      .q     (syn_in)
   );

   assign sclk_s = syn_in[0];
   assign csn_s  = syn_in[1];
   assign sdi_s  = syn_in[2];
   assign sync_s = syn_in[3];

   cfgsp_engine u_engine (
      .clk       (clk),
      .rst_n     (rst_n),
      .sclk_s    (sclk_s),
      .csn_s     (csn_s),
      .sdi_s     (sdi_s),
      .sync_s    (sync_s),
      .lsb_first (lsb_first),
      .rd_data   (rd_data),
      .addr      (addr),
      .wr_en     (wr_en),
      .wr_data   (wr_data),
      .tx_bit    (tx_bit),
      .tx_active (tx_active)
   );

   cfgsp_regbank #(
      .NUM_REGS (NUM_REGS)
   ) u_bank (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (wr_en),
      .addr    (addr),
      .wr_data (wr_data),
      .rd_data (rd_data),
      .bank_o  (cfg_o)
   );

   assign lsb_first = cfg_o[ORDER_BIT];
   assign line4     = cfg_o[LINE_BIT];

   assign sdio_oe_o = tx_active & ~line4;
   assign sdo_oe_o  = tx_active &  line4;
   assign sdio_o    = sdio_oe_o & tx_bit;
   assign sdo_o     = sdo_oe_o  & tx_bit;

   assign ramp_o  = cfg_o[2*32+14 +: 2];
   assign scale_o = cfg_o[2*32 +: 14];

   // R5: at most one line is driven at a time
   p_one_driver_r5: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({sdio_oe_o, sdo_oe_o}));

endmodule

// File: tb/cfg_serial_port_bench.sv
module cfg_serial_port_bench;

   localparam int NR   = 6;
   localparam int HALF = 40;   // ns, 10 system clocks

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic sclk = 1'b0, csn = 1'b1, sdi = 1'b0, sync = 1'b0;
   logic sdio_o, sdio_oe, sdo_o, sdo_oe;
   logic [NR*32-1:0] cfg;
   logic [1:0]  ramp;
   logic [13:0] scale;

   int checks = 0;
   int fails  = 0;
   bit done   = 1'b0;

   logic [31:0] mdl [NR];
   bit m_lsb = 1'b0;
   bit m_4w  = 1'b0;

   always #2 clk = ~clk;   // 250 MHz

   cfg_serial_port u_cfg_serial_port (
      .clk       (clk),
      .rst_n     (rst_n),
      .sclk_i    (sclk),
      .csn_i     (csn),
      .sdio_i    (sdi),
      .sync_i    (sync),
      .sdio_o    (sdio_o),
      .sdio_oe_o (sdio_oe),
      .sdo_o     (sdo_o),
      .sdo_oe_o  (sdo_oe),
      .cfg_o     (cfg),
      .ramp_o    (ramp),
      .scale_o   (scale)
   );

   function automatic int tb_bytes(input logic [4:0] a);
      if (a == 5'd1) return 3;
      if (a == 5'd2) return 2;
      return 4;
   endfunction

   task automatic chk(input string req, input string what,
                      input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
      end
   endtask

   task automatic send_bit(input logic b, output logic rb,
                           output logic o_io, output logic o_so);
      sdi = b;
      #(HALF);
      rb   = m_4w ? sdo_o : sdio_o;
      o_io = sdio_oe;
      o_so = sdo_oe;
      sclk = 1'b1;
      #(HALF);
      sclk = 1'b0;
   endtask

   // One transaction; ins is the logical instruction value.
   task automatic xfer(input logic [7:0] ins, input logic [31:0] wd,
                       output logic [31:0] rd, output bit oe_ok,
                       input int pause_at, input int abort_at);
      logic rb, o1, o2;
      int nb, total, idx;
      bit is_rd;
      nb    = tb_bytes(ins[4:0]);
      total = nb * 8;
      is_rd = ins[7];
      rd    = '0;
      oe_ok = 1'b1;
      csn   = 1'b0;
      #(HALF);
      for (int i = 0; i < 8; i++) send_bit(ins[m_lsb ? i : 7 - i], rb, o1, o2);
      for (int k = 0; k < total; k++) begin
         if (k == pause_at) begin
            csn = 1'b1;
            #(2*HALF);
            chk("R6", "enables during pause", {30'd0, sdio_oe, sdo_oe}, 32'd0);
            for (int t = 0; t < 3; t++) begin
               sclk = 1'b1; #(HALF); sclk = 1'b0; #(HALF);
            end
            csn = 1'b0;
            #(2*HALF);
         end
         if (k == abort_at) begin
            sync = 1'b1;
            #(2*HALF);
            sync = 1'b0;
            #(2*HALF);
            csn = 1'b1;
            #(2*HALF);
            return;
         end
         idx = m_lsb ? k : total - 1 - k;
         send_bit(wd[idx], rb, o1, o2);
         rd[idx] = rb;
         if (o1 !== (is_rd & ~m_4w) || o2 !== (is_rd & m_4w)) oe_ok = 1'b0;
      end
      csn = 1'b1;
      #(2*HALF);
      if (!is_rd && ins[4:0] < NR) begin
         mdl[ins[4:0]] = wd & ((nb == 4) ? 32'hFFFF_FFFF : ((32'd1 << total) - 1));
         if (ins[4:0] == 5'd0) begin
            m_lsb = wd[8];
            m_4w  = wd[7];
         end
      end
   endtask

   function automatic logic [31:0] reg_out(input int i);
      return cfg[i*32 +: 32];
   endfunction

   task automatic wr(input logic [7:0] ins, input logic [31:0] wd);
      logic [31:0] rd; bit ok;
      xfer(ins, wd, rd, ok, -1, -1);
   endtask

   task automatic t_reset;
      for (int i = 0; i < NR; i++) chk("R10", "register after reset", reg_out(i), 32'd0);
      chk("R10", "enables after reset", {30'd0, sdio_oe, sdo_oe}, 32'd0);
   endtask

   task automatic t_msb_reg2;
      wr(8'h02, 32'h0000_C123);
      chk("R3", "reg2 after MSB write", reg_out(2), 32'h0000_C123);
      chk("R9", "ramp field", {30'd0, ramp}, 32'd3);
      chk("R9", "scale field", {18'd0, scale}, 32'h0123);
   endtask

   task automatic t_readback_3w;
      logic [31:0] rd; bit ok;
      wr(8'h03, 32'hDEAD_BEEF);
      chk("R3", "reg3 after write", reg_out(3), 32'hDEAD_BEEF);
      xfer(8'h83, 32'h0, rd, ok, -1, -1);
      chk("R3", "reg3 read MSB 3-wire", rd, 32'hDEAD_BEEF);
      chk("R5", "3-wire enables", {31'd0, ok}, 32'd1);
   endtask

   task automatic t_dontcare;
      logic [31:0] rd; bit ok;
      wr(8'h62, 32'h0000_1234);
      chk("R1", "write with bits 6:5 set", reg_out(2), 32'h0000_1234);
      xfer(8'hE2, 32'h0, rd, ok, -1, -1);
      chk("R1", "read with bits 6:5 set", rd, 32'h0000_1234);
   endtask

   task automatic t_widths;
      wr(8'h01, 32'h00AB_CDEF);
      wr(8'h02, 32'h0000_5555);
      chk("R2", "reg1 is 3 bytes", reg_out(1), 32'h00AB_CDEF);
      chk("R2", "next frame after reg1", reg_out(2), 32'h0000_5555);
   endtask

   task automatic t_unmapped;
      logic [31:0] rd; bit ok;
      wr(8'h10, 32'hFFFF_FFFF);
      for (int i = 0; i < NR; i++) chk("R2", "unmapped write ignored", reg_out(i), mdl[i]);
      xfer(8'h90, 32'h0, rd, ok, -1, -1);
      chk("R2", "unmapped reads zero", rd, 32'd0);
      xfer(8'h83, 32'h0, rd, ok, -1, -1);
      chk("R2", "framing after unmapped", rd, 32'hDEAD_BEEF);
   endtask

   task automatic t_4wire;
      logic [31:0] rd; bit ok;
      wr(8'h00, 32'h0000_0080);
      xfer(8'h83, 32'h0, rd, ok, -1, -1);
      chk("R5", "4-wire read data", rd, 32'hDEAD_BEEF);
      chk("R5", "4-wire enables", {31'd0, ok}, 32'd1);
   endtask

   task automatic t_lsb;
      logic [31:0] rd; bit ok;
      wr(8'h00, 32'h0000_0180);   // switch to LSB first, keep 4-wire
      wr(8'h02, 32'h0000_8001);
      chk("R4", "reg2 after LSB write", reg_out(2), 32'h0000_8001);
      wr(8'h01, 32'h0012_3456);
      chk("R4", "reg1 after LSB write", reg_out(1), 32'h0012_3456);
      xfer(8'h81, 32'h0, rd, ok, -1, -1);
      chk("R4", "reg1 LSB read", rd, 32'h0012_3456);
      xfer(8'h83, 32'h0, rd, ok, -1, -1);
      chk("R4", "reg3 LSB read", rd, 32'hDEAD_BEEF);
      wr(8'h00, 32'h0000_0000);   // back to MSB first, 3-wire
      chk("R4", "ctrl cleared in LSB mode", reg_out(0), 32'd0);
   endtask

   task automatic t_pause;
      logic [31:0] rd; bit ok;
      xfer(8'h03, 32'h0F0F_1234, rd, ok, 13, -1);
      chk("R6", "write across pause", reg_out(3), 32'h0F0F_1234);
      xfer(8'h83, 32'h0, rd, ok, 5, -1);
      chk("R6", "read across pause", rd, 32'h0F0F_1234);
   endtask

   task automatic t_abort;
      logic [31:0] rd; bit ok;
      wr(8'h04, 32'hAAAA_5555);
      xfer(8'h04, 32'h1234_5678, rd, ok, -1, 10);
      chk("R8", "partial write not committed", reg_out(4), 32'hAAAA_5555);
      chk("R7", "abort keeps other register", reg_out(3), 32'h0F0F_1234);
      wr(8'h05, 32'h600D_F00D);
      chk("R7", "new instruction after abort", reg_out(5), 32'h600D_F00D);
      chk("R7", "reg4 still intact", reg_out(4), 32'hAAAA_5555);
   endtask

   initial begin
      for (int i = 0; i < NR; i++) mdl[i] = '0;
      repeat (5) @(negedge clk);
      rst_n = 1'b1;
      repeat (5) @(negedge clk);
      t_reset;
      t_msb_reg2;
      t_readback_3w;
      t_dontcare;
      t_widths;
      t_unmapped;
      t_4wire;
      t_lsb;
      t_pause;
      t_abort;
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

   initial begin
      #(600_000);
      if (!done) begin
         checks++;
         fails++;
         $display("FAIL watchdog actual=running expected=finished");
         $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   end

endmodule